// File: doc/BRIEF.md
# Interleaved 3D Neighbourhood Grid Memory

This block holds a cubic grid of field samples spread over N³ independently addressed memory banks (N = 4 by default, 64 banks). A grid point's bank comes from its coordinates taken modulo N in each axis. Its in-bank address is made from the remaining high coordinate bits. With this layout any N×N×N window of the grid hits each bank exactly once. As a result, the whole neighbourhood around a requested point is read in one cycle with no bank conflicts.

A lookup presents a fixed-point position (integer grid part plus fraction) on each axis, one position per cycle, in any order. The block derives the window's base corner from the integer part. It generates one address per bank and reads all banks at once. It then rotates the bank outputs into a fixed lane order that does not depend on where the window sits relative to the bank pattern. The fractional parts travel with the lookup so that a downstream interpolator receives the weights next to the samples. A write port loads single grid points. A build parameter selects the tricubic form (4×4×4, 64 lanes) or the trilinear form (2×2×2, 8 lanes).

Top module: `nbr_grid_mem`

## Requirements
- R1: After reset, nb_valid_o is 0 until a lookup has been issued.
- R2: A lookup accepted on a rising edge (lk_valid_i high) produces nb_valid_o high for exactly one cycle, after the second following rising edge. nb_valid_o is low in the cycle in between.
- R3: With NL=2, the window base on each axis is (integer part − 1) mod G, where G = 2^CW. Lane n = i + 4j + 16k, occupying bits [n·DW +: DW] of nb_data_o, carries the sample at grid point ((bx+i) mod G, (by+j) mod G, (bz+k) mod G).
- R4: Lookups on consecutive cycles, at unrelated positions, each return their own complete neighbourhood in issue order, one per cycle.
- R5: Windows that cross a grid face wrap periodically. For example, integer part 0 gives base G−1, and integer part G−1 gives coordinates G−2, G−1, 0, 1.
- R6: wr_en_i stores wr_data_i at grid point (wr_x_i, wr_y_i, wr_z_i). A lookup issued on the cycle after the write already returns the new value.
- R7: A write and a lookup that touch the same grid point on the same edge return the value from before that write. The next lookup returns the new value.
- R8: nb_frac_x_o, nb_frac_y_o and nb_frac_z_o equal the low FW bits of the matching lk_pos inputs of the lookup whose data is on nb_data_o.
- R9: With NL=1, the base is the integer part itself (no offset). Eight lanes n = i + 2j + 4k carry the samples at (base + (i, j, k)) mod G.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request this cycle |
| lk_pos_x_i | input | CW+FW | X position: integer grid part in high CW bits, fraction in low FW bits |
| lk_pos_y_i | input | CW+FW | Y position, same format |
| lk_pos_z_i | input | CW+FW | Z position, same format |
| wr_en_i | input | 1 | Write one grid point |
| wr_x_i | input | CW | Write X coordinate |
| wr_y_i | input | CW | Write Y coordinate |
| wr_z_i | input | CW | Write Z coordinate |
| wr_data_i | input | DW | Write value |
| nb_valid_o | output | 1 | Neighbourhood output valid |
| nb_data_o | output | N³·DW | Neighbourhood samples in lane order |
| nb_frac_x_o | output | FW | X fraction of the returned lookup |
| nb_frac_y_o | output | FW | Y fraction of the returned lookup |
| nb_frac_z_o | output | FW | Z fraction of the returned lookup |

## Verification
A grid-point write and a lookup whose window covers that same point can share one clock edge. In that case the bank's write and read of one address coincide. The bench provokes this by driving wr_en_i and lk_valid_i together on one falling edge, with the written point inside the requested window. It expects the pre-write sample in that lane, with every other lane unchanged. A second lookup right after must show the new value, and a further test checks that a write followed one cycle later by a lookup already sees the update.

// File: rtl/nbr_pkg.sv
package nbr_pkg;

  // Residue of bank b along an axis (0=x, 1=y, 2=z)
  function automatic int bank_res(int b, int axis, int nl);
    return (b >> (axis * nl)) & ((1 << nl) - 1);
  endfunction

  // Bank feeding output lane for a given base residue per axis
  function automatic int rot_bank(int lane, int rx, int ry, int rz, int nl);
    int n;
    int i, j, k;
    n = 1 << nl;
    i = lane % n;
    j = (lane / n) % n;
    k = lane / (n * n);
    return ((rx + i) % n) + n * ((ry + j) % n) + n * n * ((rz + k) % n);
  endfunction

endpackage

// File: rtl/nbr_addr_gen.sv
module nbr_addr_gen import nbr_pkg::*; #(
  parameter int CW = 3,
  parameter int NL = 2,
  localparam int NB = 1 << (3 * NL),
  localparam int AW = 3 * (CW - NL)
) (
  input  logic [CW-1:0]          base_x_i,
  input  logic [CW-1:0]          base_y_i,
  input  logic [CW-1:0]          base_z_i,
  output logic [NB-1:0][AW-1:0]  addr_o
);
  localparam int HW = CW - NL;

  logic [HW-1:0] hi_x, hi_y, hi_z;
  logic [NL-1:0] lo_x, lo_y, lo_z;

  assign hi_x = base_x_i[CW-1:NL];
  assign hi_y = base_y_i[CW-1:NL];
  assign hi_z = base_z_i[CW-1:NL];
  assign lo_x = base_x_i[NL-1:0];
  assign lo_y = base_y_i[NL-1:0];
  assign lo_z = base_z_i[NL-1:0];

  // A bank whose residue lies below the base residue holds the next block up
  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam logic [NL-1:0] RX = NL'(bank_res(b, 0, NL));
    localparam logic [NL-1:0] RY = NL'(bank_res(b, 1, NL));
    localparam logic [NL-1:0] RZ = NL'(bank_res(b, 2, NL));
    logic [HW-1:0] ax, ay, az;
    assign ax = hi_x + HW'(lo_x > RX);
    assign ay = hi_y + HW'(lo_y > RY);
    assign az = hi_z + HW'(lo_z > RZ);
    assign addr_o[b] = {az, ay, ax};
  end

endmodule

// File: rtl/nbr_bank.sv
module nbr_bank #(
  parameter int DW = 16,
  parameter int AW = 3,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [DW-1:0] wd_i,
  input  logic [AW-1:0] ra_i,
  output logic [DW-1:0] rd_o
);
  logic [DW-1:0] mem [DEPTH];

  // Read sees the contents before a same-edge write
  always_ff @(posedge clk_i) begin
    if (we_i) mem[wa_i] <= wd_i;
    rd_o <= mem[ra_i];
  end

  // R6: a write is visible to a read issued on the next cycle
  a_r6_write_then_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i ##1 (ra_i == $past(wa_i)) |=> rd_o == $past(wd_i, 2));

endmodule

// File: rtl/nbr_perm.sv
module nbr_perm import nbr_pkg::*; #(
  parameter int DW = 16,
  parameter int NL = 2,
  localparam int NB = 1 << (3 * NL),
  localparam int NBW = 3 * NL
) (
  input  logic                   clk_i,
  input  logic [NB-1:0][DW-1:0]  bank_i,
  input  logic [NL-1:0]          rx_i,
  input  logic [NL-1:0]          ry_i,
  input  logic [NL-1:0]          rz_i,
  output logic [NB-1:0][DW-1:0]  lane_o
);
  logic [NBW-1:0] sel [NB];

  always_comb begin
    for (int n = 0; n < NB; n++)
      sel[n] = NBW'(rot_bank(n, int'(rx_i), int'(ry_i), int'(rz_i), NL));
  end

  always_ff @(posedge clk_i) begin
    for (int n = 0; n < NB; n++) lane_o[n] <= bank_i[sel[n]];
  end

endmodule

// File: rtl/nbr_grid_mem.sv
module nbr_grid_mem #(
  parameter int CW = 3,
  parameter int FW = 4,
  parameter int DW = 16,
  parameter int NL = 2,
  localparam int NB = 1 << (3 * NL),
  localparam int PW = CW + FW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lk_valid_i,
  input  logic [PW-1:0]    lk_pos_x_i,
  input  logic [PW-1:0]    lk_pos_y_i,
  input  logic [PW-1:0]    lk_pos_z_i,
  input  logic             wr_en_i,
  input  logic [CW-1:0]    wr_x_i,
  input  logic [CW-1:0]    wr_y_i,
  input  logic [CW-1:0]    wr_z_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic             nb_valid_o,
  output logic [NB*DW-1:0] nb_data_o,
  output logic [FW-1:0]    nb_frac_x_o,
  output logic [FW-1:0]    nb_frac_y_o,
  output logic [FW-1:0]    nb_frac_z_o
);
  localparam int N   = 1 << NL;
  localparam int HW  = CW - NL;
  localparam int AW  = 3 * HW;
  localparam int NBW = 3 * NL;
  localparam int OFF = N / 2 - 1;

  // Window base: integer part pulled back so the point sits near the centre
  logic [CW-1:0] base_x, base_y, base_z;
  assign base_x = lk_pos_x_i[PW-1:FW] - CW'(OFF);
  assign base_y = lk_pos_y_i[PW-1:FW] - CW'(OFF);
  assign base_z = lk_pos_z_i[PW-1:FW] - CW'(OFF);

  logic [NB-1:0][AW-1:0] rd_addr;

  nbr_addr_gen #(.CW(CW), .NL(NL)) u_addr (
    .base_x_i (base_x),
    .base_y_i (base_y),
    .base_z_i (base_z),
    .addr_o   (rd_addr)
  );

  logic [NBW-1:0] wr_bank;
  logic [AW-1:0]  wr_addr;
  assign wr_bank = {wr_z_i[NL-1:0], wr_y_i[NL-1:0], wr_x_i[NL-1:0]};
  assign wr_addr = {wr_z_i[CW-1:NL], wr_y_i[CW-1:NL], wr_x_i[CW-1:NL]};

  logic [NB-1:0][DW-1:0] bank_rd;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    nbr_bank #(.DW(DW), .AW(AW)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (wr_en_i && (wr_bank == NBW'(b))),
      .wa_i   (wr_addr),
      .wd_i   (wr_data_i),
      .ra_i   (rd_addr[b]),
      .rd_o   (bank_rd[b])
    );
  end

  // Stage 1 sidebands (aligned with bank read data)
  logic          v1_q, v2_q;
  logic [NL-1:0] rx1_q, ry1_q, rz1_q;
  logic [FW-1:0] fx1_q, fy1_q, fz1_q;
  logic [FW-1:0] fx2_q, fy2_q, fz2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= lk_valid_i;
      v2_q <= v1_q;
    end
  end

  always_ff @(posedge clk_i) begin
    rx1_q <= base_x[NL-1:0];
    ry1_q <= base_y[NL-1:0];
    rz1_q <= base_z[NL-1:0];
    fx1_q <= lk_pos_x_i[FW-1:0];
    fy1_q <= lk_pos_y_i[FW-1:0];
    fz1_q <= lk_pos_z_i[FW-1:0];
    fx2_q <= fx1_q;
    fy2_q <= fy1_q;
    fz2_q <= fz1_q;
  end

  logic [NB-1:0][DW-1:0] lanes;

  nbr_perm #(.DW(DW), .NL(NL)) u_perm (
    .clk_i  (clk_i),
    .bank_i (bank_rd),
    .rx_i   (rx1_q),
    .ry_i   (ry1_q),
    .rz_i   (rz1_q),
    .lane_o (lanes)
  );

  assign nb_valid_o  = v2_q;
  assign nb_data_o   = lanes;
  assign nb_frac_x_o = fx2_q;
  assign nb_frac_y_o = fy2_q;
  assign nb_frac_z_o = fz2_q;

  // R2: result appears two edges after acceptance
  a_r2_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> ##1 nb_valid_o);
  a_r2_valid_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |=> ##1 !nb_valid_o);
  // R8: fractions ride along with their lookup
  a_r8_frac_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> ##1 (nb_frac_x_o == $past(lk_pos_x_i[FW-1:0], 2)) &&
                       (nb_frac_y_o == $past(lk_pos_y_i[FW-1:0], 2)) &&
                       (nb_frac_z_o == $past(lk_pos_z_i[FW-1:0], 2)));

endmodule

// File: tb/tb_nbr_grid_mem.sv
module tb_nbr_grid_mem;
  localparam int G = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic lk_valid_i = 1'b0;
  logic [6:0] lk_pos_x_i = '0, lk_pos_y_i = '0, lk_pos_z_i = '0;
  logic wr_en_i = 1'b0;
  logic [2:0] wr_x_i = '0, wr_y_i = '0, wr_z_i = '0;
  logic [15:0] wr_data_i = '0;

  logic nb_valid_o, lin_valid;
  logic [1023:0] nb_data_o;
  logic [127:0]  lin_data;
  logic [3:0] nb_frac_x_o, nb_frac_y_o, nb_frac_z_o;
  logic [3:0] lin_fx, lin_fy, lin_fz;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  logic [15:0] gm [G][G][G];

  always #10 clk_i = ~clk_i;

  nbr_grid_mem dut (
    .clk_i, .rst_ni, .lk_valid_i, .lk_pos_x_i, .lk_pos_y_i, .lk_pos_z_i,
    .wr_en_i, .wr_x_i, .wr_y_i, .wr_z_i, .wr_data_i,
    .nb_valid_o, .nb_data_o, .nb_frac_x_o, .nb_frac_y_o, .nb_frac_z_o
  );

  nbr_grid_mem #(.NL(1)) dut_lin (
    .clk_i, .rst_ni, .lk_valid_i, .lk_pos_x_i, .lk_pos_y_i, .lk_pos_z_i,
    .wr_en_i, .wr_x_i, .wr_y_i, .wr_z_i, .wr_data_i,
    .nb_valid_o (lin_valid), .nb_data_o (lin_data),
    .nb_frac_x_o (lin_fx), .nb_frac_y_o (lin_fy), .nb_frac_z_o (lin_fz)
  );

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 20000", cycles);
      finish_run();
    end
  end

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int wrap(int v);
    return ((v % G) + G) % G;
  endfunction

  function automatic logic [1023:0] exp_vec(int fx, int fy, int fz, int nl);
    logic [1023:0] v = '0;
    int n = 1 << nl;
    int off = n / 2 - 1;
    for (int k = 0; k < n; k++)
      for (int j = 0; j < n; j++)
        for (int i = 0; i < n; i++)
          v[(i + n*j + n*n*k)*16 +: 16] =
            gm[wrap(fx - off + i)][wrap(fy - off + j)][wrap(fz - off + k)];
    return v;
  endfunction

  // Compare whole neighbourhoods; report the first differing lane
  task automatic chk_nbr(string req, int fx, int fy, int fz);
    logic [1023:0] e4 = exp_vec(fx, fy, fz, 2);
    logic [1023:0] e2 = exp_vec(fx, fy, fz, 1);
    int bad = -1;
    for (int n = 0; n < 64; n++)
      if (bad < 0 && nb_data_o[n*16 +: 16] !== e4[n*16 +: 16]) bad = n;
    n_checks++;
    if (bad >= 0) begin
      n_fail++;
      $display("FAIL %s 4x4x4 at (%0d,%0d,%0d) lane %0d: actual %0h expected %0h",
               req, fx, fy, fz, bad, nb_data_o[bad*16 +: 16], e4[bad*16 +: 16]);
    end
    chk({req, " R9"}, "2x2x2 neighbourhood", 64'(lin_data[127:64] ^ {lin_data[63:0]}) ,
        64'(e2[127:64] ^ e2[63:0]));
    chk({req, " R9"}, "2x2x2 low lanes", lin_data[63:0], e2[63:0]);
  endtask

  task automatic drive(int fx, int fy, int fz, logic [3:0] fr);
    lk_valid_i = 1'b1;
    lk_pos_x_i = {3'(fx), fr};
    lk_pos_y_i = {3'(fy), fr ^ 4'h5};
    lk_pos_z_i = {3'(fz), fr ^ 4'hA};
  endtask

  task automatic chk_frac(logic [3:0] fr);
    chk("R8", "frac x", 64'(nb_frac_x_o), 64'(fr));
    chk("R8", "frac y", 64'(nb_frac_y_o), 64'(fr ^ 4'h5));
    chk("R8", "frac z", 64'(nb_frac_z_o), 64'(fr ^ 4'hA));
    chk("R8 R9", "lin frac x", 64'(lin_fx), 64'(fr));
  endtask

  task automatic load_grid();
    for (int x = 0; x < G; x++)
      for (int y = 0; y < G; y++)
        for (int z = 0; z < G; z++) begin
          @(negedge clk_i);
          gm[x][y][z] = 16'(((x*64 + y*8 + z) * 37 + 5)) ^ 16'hA5A5;
          wr_en_i = 1'b1; wr_x_i = 3'(x); wr_y_i = 3'(y); wr_z_i = 3'(z);
          wr_data_i = gm[x][y][z];
        end
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "valid after reset", 64'(nb_valid_o), 0);
    chk("R1", "lin valid after reset", 64'(lin_valid), 0);
  endtask

  task automatic t_single();
    @(negedge clk_i); drive(3, 4, 5, 4'h9);
    @(negedge clk_i); lk_valid_i = 1'b0;
    chk("R2", "valid one cycle after accept", 64'(nb_valid_o), 0);
    @(negedge clk_i);
    chk("R2", "valid two cycles after accept", 64'(nb_valid_o), 1);
    chk_nbr("R3", 3, 4, 5);
    chk_frac(4'h9);
    @(negedge clk_i);
    chk("R2", "valid drops after one cycle", 64'(nb_valid_o), 0);
  endtask

  task automatic t_stream();
    int px[6] = '{6, 1, 4, 2, 7, 3};
    int py[6] = '{2, 5, 0, 6, 3, 1};
    int pz[6] = '{3, 3, 7, 1, 5, 6};
    for (int t = 0; t < 8; t++) begin
      @(negedge clk_i);
      if (t >= 2) begin
        chk("R4", "streamed valid", 64'(nb_valid_o), 1);
        chk_nbr("R4", px[t-2], py[t-2], pz[t-2]);
        chk_frac(4'(t*3 - 5));
      end
      if (t < 6) drive(px[t], py[t], pz[t], 4'(t*3 + 1));
      else lk_valid_i = 1'b0;
    end
  endtask

  task automatic t_wrap();
    @(negedge clk_i); drive(0, 0, 0, 4'h0);
    @(negedge clk_i); drive(7, 7, 7, 4'hF);
    @(negedge clk_i); lk_valid_i = 1'b0;
    chk_nbr("R5", 0, 0, 0);
    @(negedge clk_i);
    chk_nbr("R5", 7, 7, 7);
    chk("R5", "wrapped lane 63 source", 64'(nb_data_o[63*16 +: 16]), 64'(gm[1][1][1]));
  endtask

  task automatic t_write_next();
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_x_i = 3'd2; wr_y_i = 3'd2; wr_z_i = 3'd2; wr_data_i = 16'hBEEF;
    gm[2][2][2] = 16'hBEEF;
    @(negedge clk_i);
    wr_en_i = 1'b0; drive(2, 2, 2, 4'h3);
    @(negedge clk_i); lk_valid_i = 1'b0;
    @(negedge clk_i);
    chk("R6", "lane holding written point", 64'(nb_data_o[21*16 +: 16]), 64'h BEEF);
    chk_nbr("R6", 2, 2, 2);
  endtask

  task automatic t_collide();
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_x_i = 3'd5; wr_y_i = 3'd5; wr_z_i = 3'd5; wr_data_i = 16'h1234;
    drive(5, 5, 5, 4'h7);
    @(negedge clk_i);
    wr_en_i = 1'b0; drive(5, 5, 5, 4'h7);
    @(negedge clk_i);
    lk_valid_i = 1'b0;
    chk_nbr("R7", 5, 5, 5);
    chk("R7", "old value on same-edge write", 64'(nb_data_o[21*16 +: 16]),
        64'(16'(((5*64 + 5*8 + 5) * 37 + 5)) ^ 16'hA5A5));
    gm[5][5][5] = 16'h1234;
    @(negedge clk_i);
    chk("R7", "new value on next lookup", 64'(nb_data_o[21*16 +: 16]), 64'h1234);
    chk_nbr("R7", 5, 5, 5);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    load_grid();
    t_single();
    t_stream();
    t_wrap();
    t_write_next();
    t_collide();
    repeat (2) @(negedge clk_i);
    finish_run();
  end

endmodule